// File: doc/BRIEF.md
# Double-Buffered SPI Master Transceiver

This block is an SPI master that moves one byte at a time in both directions and makes its own serial clock. Software talks to it through a small register port. It writes outgoing bytes into a transmit holding register and reads incoming bytes from a receive holding register. Between them sits the shift register that drives MOSI and samples MISO. If the block is idle, a byte written to the holding register moves into the shift register on the next clock and the transfer begins. If a byte is waiting when the current one finishes, it moves across in that same cycle, so the bytes go out back to back with no idle SCLK period between them.

A control register selects one of four clock modes. Mode bit 0 is the clock polarity and mode bit 1 is the clock phase. A divider register sets the SCLK rate. A status register holds four flags:

- transmit-holding-empty, which clears only when a byte is written to the transmit holding register;
- transfer-complete, which clears when the status register is read;
- receive-full, which clears when the status register is read;
- busy, which is a live flag.

One interrupt output follows either the holding-empty flag or the transfer-complete flag. It stays high until software clears that flag.

Register map (2-bit address). Address 0: write loads the transmit holding register, read returns the receive holding register. Address 1: control register, read/write; bit 0 is polarity, bit 1 is phase, bit 2 is the interrupt source (0 = holding-empty, 1 = transfer-complete). Address 2: status register, read only, and a read clears it; bit 0 is holding-empty, bit 1 is transfer-complete, bit 2 is receive-full, bit 3 is busy. Address 3: half-period divider value H, read/write.

Top module: `dbuf_spi_master`

## Requirements
- R1: After reset, status reads 0x01, SCLK and MOSI are 0, the receive register reads 0, and irq is 1, because the reset interrupt source is holding-empty.
- R2: A write to address 0 while the block is idle loads the shift register one clock after the write, and busy is set from that clock on.
- R3: Each transfer is 8 bits, most significant bit first. MOSI sends the written byte while MISO is received into the shift register in the same transfer.
- R4: Control bit 0 is the SCLK polarity and sets the level SCLK holds while idle. SCLK is back at that level after each byte.
- R5: With control bit 1 (phase) at 0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge; MOSI carries bit 7 as soon as the shift register loads. With phase at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Every byte takes exactly 16 SCLK edges.
- R6: After the 16th edge, the received byte is readable at address 0, and receive-full (status bit 2) is set.
- R7: A byte written while a transfer is in progress moves into the shift register on the clock of the last edge. Busy stays high and holding-empty is set again.
- R8: Holding-empty (status bit 0) clears on a write to address 0, and a status read does not clear it.
- R9: Transfer-complete (status bit 1) is set when a byte finishes and no byte is waiting. A status read clears it and receive-full, but a flag set in the same clock as the read wins.
- R10: irq equals holding-empty when control bit 2 is 0 and transfer-complete when it is 1. irq stays high until that flag is cleared.
- R11: Each SCLK half period lasts H+1 system clocks, where H is the value at address 3. With H = 0, SCLK is the system clock divided by 2.
- R12: Busy (status bit 3) is high from the load of the shift register until the clock of the last edge, and low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read at address 2 clears the status flags |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational by default) |
| irq | output | 1 | Interrupt, level, from the selected status flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Take the write to address 0 as being registered at edge E0. The shift register loads at E1. The first SCLK edge comes H+1 clocks later, and the last edge, which also sets receive-full, transfer-complete or the next handoff, comes at E1 + 16(H+1). The bench reads status at fixed cycle offsets from its own writes. One test reads in the cycle just before the last edge and expects busy still high, then reads in the cycle after it and expects the flags set. Other tests wait a known margin past the end of the byte. A model slave reacts to the SCLK edges and records the SCLK edge times, so the bench can check bit order, phase and half-period length.

// File: rtl/dbspi_pkg.sv
package dbspi_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_DIV  = 2'd3
   } reg_addr_e;

   localparam int CTL_CPOL = 0;
   localparam int CTL_CPHA = 1;
   localparam int CTL_ISEL = 2;
   localparam int CTL_BITS = 3;

   localparam int ST_TXE  = 0;
   localparam int ST_TXC  = 1;
   localparam int ST_RXF  = 2;
   localparam int ST_BSY  = 3;
   localparam int ST_BITS = 4;

   typedef struct packed {
      logic irq_sel;
      logic cpha;
      logic cpol;
   } spi_cfg_t;
endpackage

// File: rtl/dbspi_clkgen.sv
module dbspi_clkgen #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cpol,
   input  logic [DIV_W-1:0] half,
   output logic             sclk,
   output logic             lead,
   output logic             trail,
   output logic             last
);
   localparam int EDGES = 2 * DATA_W;
   localparam int ECW   = $clog2(EDGES);

   logic [DIV_W-1:0] cnt;
   logic [ECW-1:0]   edge_cnt;
   logic             sclk_q;
   logic             tick;

   initial begin
      AST_PARAM_DIV: assert (DIV_W >= 1) else $error("DIV_W must be at least 1"); // R11
   end

   assign tick  = run && (cnt == half);
   assign lead  = tick && !edge_cnt[0];
   assign trail = tick && edge_cnt[0];
   assign last  = trail && (edge_cnt == ECW'(EDGES - 1));
   assign sclk  = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         edge_cnt <= '0;
         sclk_q   <= 1'b0;
      end else if (!run) begin
         cnt      <= '0;
         edge_cnt <= '0;
         sclk_q   <= cpol;
      end else if (tick) begin
         cnt      <= '0;
         sclk_q   <= ~sclk_q;
         edge_cnt <= last ? '0 : edge_cnt + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run) && $stable(cpol)) |-> (sclk == cpol)); // R4

   AST_EDGES_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cnt != '0) |-> run); // R12
endmodule

// File: rtl/dbspi_shifter.sv
module dbspi_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              lead,
   input  logic              trail,
   input  logic              last,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              miso,
   output logic              busy,
   output logic              mosi,
   output logic              take_hold,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] shift_in;
   logic              samp;
   logic              mosi_q;
   logic              busy_q;
   logic              start;

   assign start     = !busy_q && hold_full;
   assign done      = busy_q && last;
   assign take_hold = start || (done && hold_full);
   assign shift_in  = {shreg[MSB-1:0], (cpha ? miso : samp)};
   assign busy      = busy_q;
   assign mosi      = mosi_q;
   assign rx_byte   = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         rx_q   <= '0;
         samp   <= 1'b0;
         mosi_q <= 1'b0;
         busy_q <= 1'b0;
      end else if (start) begin
         shreg  <= hold_data;
         busy_q <= 1'b1;
         if (!cpha) mosi_q <= hold_data[MSB];
      end else if (busy_q && lead) begin
         if (!cpha) samp   <= miso;
         else       mosi_q <= shreg[MSB];
      end else if (busy_q && trail) begin
         if (last) begin
            rx_q <= shift_in;
            if (hold_full) begin
               shreg <= hold_data;
               if (!cpha) mosi_q <= hold_data[MSB];
            end else begin
               shreg  <= shift_in;
               busy_q <= 1'b0;
            end
         end else begin
            shreg <= shift_in;
            if (!cpha) mosi_q <= shreg[MSB-1];
         end
      end
   end

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> busy_q); // R12

   AST_MOSI_STILL_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !cpha && lead && $stable(cpha)) |=> $stable(mosi_q)); // R5
endmodule

// File: rtl/dbspi_regs.sv
module dbspi_regs
   import dbspi_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 8,
   parameter int READ_LAT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              take_hold,
   input  logic              done,
   input  logic              busy,
   input  logic [DATA_W-1:0] rx_byte,
   output spi_cfg_t          cfg,
   output logic [DIV_W-1:0]  half,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_data,
   output logic              irq
);
   spi_cfg_t          cfg_q;
   logic [DIV_W-1:0]  half_q;
   logic [DATA_W-1:0] hold_q;
   logic              full_q;
   logic              txe_q;
   logic              txc_q;
   logic              rxf_q;
   logic              wr_tx;
   logic              rd_stat;
   logic [DATA_W-1:0] rd_mux;

   initial begin
      AST_PARAM_LATENCY: assert (READ_LAT == 0 || READ_LAT == 1)
         else $error("READ_LAT must be 0 or 1");
      AST_PARAM_DIVFIT: assert (DIV_W <= DATA_W)
         else $error("DIV_W must fit in the data bus"); // R11
   end

   assign wr_tx     = bus_wr && (bus_addr == REG_DATA);
   assign rd_stat   = bus_rd && (bus_addr == REG_STAT);
   assign cfg       = cfg_q;
   assign half      = half_q;
   assign hold_full = full_q;
   assign hold_data = hold_q;
   assign irq       = cfg_q.irq_sel ? txc_q : txe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         half_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == REG_CTRL) cfg_q  <= spi_cfg_t'(bus_wdata[CTL_BITS-1:0]);
         if (bus_addr == REG_DIV)  half_q <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         txe_q  <= 1'b1;
      end else if (wr_tx) begin
         hold_q <= bus_wdata;
         full_q <= 1'b1;
         txe_q  <= 1'b0;
      end else if (take_hold) begin
         full_q <= 1'b0;
         txe_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txc_q <= 1'b0;
         rxf_q <= 1'b0;
      end else begin
         if (done && !full_q) txc_q <= 1'b1;
         else if (rd_stat)    txc_q <= 1'b0;
         if (done)            rxf_q <= 1'b1;
         else if (rd_stat)    rxf_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         REG_DATA: rd_mux = rx_byte;
         REG_CTRL: rd_mux[CTL_BITS-1:0] = cfg_q;
         REG_STAT: begin
            rd_mux[ST_TXE] = txe_q;
            rd_mux[ST_TXC] = txc_q;
            rd_mux[ST_RXF] = rxf_q;
            rd_mux[ST_BSY] = busy;
         end
         default:  rd_mux[DIV_W-1:0] = half_q;
      endcase
   end

   generate
      if (READ_LAT == 0) begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end else begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_rd) rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end
   endgenerate

   AST_TXE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tx |=> !txe_q); // R8

   AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !done) |=> (!txc_q && !rxf_q)); // R9

   AST_TXC_NEEDS_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txc_q) |-> $past(done && !full_q)); // R9
endmodule

// File: rtl/dbuf_spi_master.sv
module dbuf_spi_master
   import dbspi_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 8,
   parameter int READ_LAT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   spi_cfg_t          cfg;
   logic [DIV_W-1:0]  half;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              take_hold;
   logic              done;
   logic              busy;
   logic [DATA_W-1:0] rx_byte;
   logic              lead;
   logic              trail;
   logic              last;

   initial begin
      AST_PARAM_WIDTH: assert (DATA_W >= ST_BITS)
         else $error("DATA_W must hold the status bits"); // R3
   end

   dbspi_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .READ_LAT(READ_LAT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .take_hold (take_hold),
      .done      (done),
      .busy      (busy),
      .rx_byte   (rx_byte),
      .cfg       (cfg),
      .half      (half),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .irq       (irq)
   );

   dbspi_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .cpol  (cfg.cpol),
      .half  (half),
      .sclk  (sclk),
      .lead  (lead),
      .trail (trail),
      .last  (last)
   );

   dbspi_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpha      (cfg.cpha),
      .lead      (lead),
      .trail     (trail),
      .last      (last),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .miso      (miso),
      .busy      (busy),
      .mosi      (mosi),
      .take_hold (take_hold),
      .done      (done),
      .rx_byte   (rx_byte)
   );

   AST_HANDOFF_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hold_full) |=> busy); // R7
endmodule

// File: tb/dbuf_spi_master_test.sv
`timescale 1ns/1ps
module dbuf_spi_master_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic       sclk;
   logic       mosi;
   logic       miso = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   bit        slv_en = 1'b0;
   bit        cur_cpol = 1'b0;
   bit        cur_cpha = 1'b0;
   logic [15:0] s_tx;
   logic [15:0] s_rx;
   int        s_edges;
   realtime   t0;
   realtime   t1;

   dbuf_spi_master uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   always #10 clk = ~clk;

   // model slave
   always @(sclk) begin
      if (slv_en) begin
         if (s_edges == 0) t0 = $realtime;
         if (s_edges == 1) t1 = $realtime;
         s_edges++;
         if (!cur_cpha) begin
            if (sclk != cur_cpol) s_rx = {s_rx[14:0], mosi};
            else begin
               s_tx = {s_tx[14:0], 1'b0};
               miso = s_tx[15];
            end
         end else begin
            if (sclk != cur_cpol) begin
               miso = s_tx[15];
               s_tx = {s_tx[14:0], 1'b0};
            end else s_rx = {s_rx[14:0], mosi};
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic setup(input logic [1:0] mode, input logic isel, input int h, input logic [15:0] resp);
      logic [7:0] junk;
      slv_en = 1'b0;
      bus_write(2'd3, 8'(h));
      bus_write(2'd1, {5'd0, isel, mode});
      idle(2);
      cur_cpol = mode[0];
      cur_cpha = mode[1];
      s_tx = resp;
      s_rx = '0;
      s_edges = 0;
      miso = mode[1] ? 1'b0 : resp[15];
      bus_read(2'd2, junk);
      slv_en = 1'b1;
   endtask

   task automatic test_reset;
      logic [7:0] v;
      chk("R1 sclk", sclk, 1'b0);
      chk("R1 mosi", mosi, 1'b0);
      chk("R1 irq", irq, 1'b1);
      bus_read(2'd2, v);
      chk("R1 status", v, 8'h01);
      bus_read(2'd0, v);
      chk("R1 rx", v, 8'h00);
   endtask

   task automatic test_mode(input logic [1:0] mode, input int h, input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] v;
      setup(mode, 1'b0, h, {rx, 8'h00});
      chk("R4 idle level", sclk, mode[0]);
      bus_write(2'd0, tx);
      bus_read(2'd2, v);
      chk("R2 busy after load", v[3], 1'b1);
      chk("R12 busy", v[3], 1'b1);
      if (!mode[1]) chk("R5 first bit on load", mosi, tx[7]);
      idle(16 * (h + 1) + 6);
      chk("R3 slave got byte msb first", s_rx[7:0], tx);
      chk("R5 sixteen edges", s_edges, 16);
      chk("R11 half period ns", int'(t1 - t0), (h + 1) * 20);
      chk("R4 idle after byte", sclk, mode[0]);
      bus_read(2'd0, v);
      chk("R6 rx byte", v, rx);
      bus_read(2'd2, v);
      chk("R6 status after byte", v, 8'h07);
   endtask

   task automatic test_exact_end;
      logic [7:0] v;
      setup(2'd0, 1'b0, 1, 16'h5A00);
      bus_write(2'd0, 8'hC3);
      idle(31);
      bus_read(2'd2, v);
      chk("R12 busy before last edge", v, 8'h09);
      bus_read(2'd2, v);
      chk("R9 set wins over read", v, 8'h07);
      bus_read(2'd0, v);
      chk("R6 rx exact", v, 8'h5A);
   endtask

   task automatic test_double;
      logic [7:0] v;
      setup(2'd0, 1'b0, 0, 16'h3CA5);
      bus_write(2'd0, 8'h81);
      bus_write(2'd0, 8'h7E);
      bus_read(2'd2, v);
      chk("R8 holding full", v, 8'h08);
      idle(15);
      bus_read(2'd2, v);
      chk("R7 handoff status", v, 8'h0D);
      bus_read(2'd0, v);
      chk("R7 first rx", v, 8'h3C);
      idle(20);
      bus_read(2'd2, v);
      chk("R9 complete after last", v, 8'h07);
      bus_read(2'd0, v);
      chk("R7 second rx", v, 8'hA5);
      chk("R7 back to back bytes", s_rx, 16'h817E);
      chk("R7 edges", s_edges, 32);
   endtask

   task automatic test_clear;
      logic [7:0] v;
      setup(2'd2, 1'b0, 0, 16'hF000);
      bus_write(2'd0, 8'h11);
      idle(24);
      bus_read(2'd2, v);
      chk("R9 flags set", v, 8'h07);
      bus_read(2'd2, v);
      chk("R8 txe survives read, R9 cleared", v, 8'h01);
   endtask

   task automatic test_irq;
      logic [7:0] v;
      setup(2'd0, 1'b1, 0, 16'h0000);
      chk("R10 complete source low", irq, 1'b0);
      bus_write(2'd0, 8'h42);
      idle(24);
      chk("R10 complete raises irq", irq, 1'b1);
      idle(10);
      chk("R10 irq held", irq, 1'b1);
      bus_read(2'd2, v);
      #1 chk("R10 read clears irq", irq, 1'b0);
      slv_en = 1'b0;
      bus_write(2'd1, 8'h00);
      idle(1);
      chk("R10 empty source", irq, 1'b1);
      bus_write(2'd0, 8'h24);
      chk("R10 write clears empty", irq, 1'b0);
      idle(24);
      chk("R10 empty again", irq, 1'b1);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      test_reset();
      test_mode(2'd0, 0, 8'hA5, 8'h3C);
      test_mode(2'd1, 1, 8'h96, 8'hE1);
      test_mode(2'd2, 3, 8'h5B, 8'h0F);
      test_mode(2'd3, 2, 8'hC8, 8'h71);
      test_exact_end();
      test_double();
      test_clear();
      test_irq();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule